// File: doc/BRIEF.md
# DMA Word Transfer Sequencer with External Terminate

This block steps one DMA channel through the states of each word transfer and counts down the words left. Software (or a channel front end) loads a word count while the block is idle, which arms it. A request then starts a transfer. Each word passes through five active phases. In the third phase the word is taken off the count. When the count goes from zero to all ones, the transfer ends with a terminal-count indication.

An active-low external terminate line can stop a transfer early. The line is first synchronised. It is then caught in a latch only while the sequencer is active, and it is acted on only in the S2 phase. If the sequencer drops back to idle before it reaches S2, the latched request is thrown away. Any pulse on the line while the sequencer is idle, including a pulse between bursts in demand mode, is not seen at all.

In single mode every word returns the sequencer to idle, and a new request starts the next word. In demand mode the sequencer goes straight on to the next word for as long as the request is held. The block has no data stream, so its pins are plain control and status lines with no handshake.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset, `phase_o` is 0 (idle), `busy_o`, `eop_o` and `tc_o` are low, `cnt_o` is zero, and the block is not armed.
- R2: `load_i` is accepted only while idle. It copies `count_i` into `cnt_o` on the next cycle and arms the block. A load while active changes nothing. A load takes priority over starting a transfer in the same cycle.
- R3: `phase_o` encodes idle=0, S0=1, S1=2, S2=3, S3=4, S4=5. An armed idle block with `dreq_i` high moves to S0. The active order is S0, S1, S2, S3, S4, one cycle each, and `busy_o` is high exactly when `phase_o` is not 0.
- R4: `cnt_o` drops by one, modulo 2^CNT_W, at the clock that ends S3, and at no other time except a load.
- R5: If a decrement takes the count from zero to all ones, the clock that ends S4 returns to idle and disarms the block. In the following cycle `eop_o` and `tc_o` are both high for one cycle.
- R6: In single mode (`demand_i` low), S4 always returns to idle. The block stays armed, and the next word starts when `dreq_i` is high in idle.
- R7: In demand mode (`demand_i` high), S4 goes to S1 if `dreq_i` is high and to idle otherwise. The block stays armed, and the count is kept across the pause.
- R8: A terminate that reaches the latch input while the sequencer is idle is not latched and has no effect.
- R9: A terminate latched while active, still pending at the start of an S2 cycle, ends that cycle in idle with the block disarmed and `cnt_o` unchanged. The next cycle has `eop_o` high with `tc_o` low, for one cycle.
- R10: Any cycle spent in idle clears a latched terminate, so a request caught after S2 in single mode, or before a demand-mode pause, has no effect on later words.
- R11: `ext_term_n_i` is active low and passes through two flops, so its level takes effect on the latch two clocks after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load word count and arm (idle only) |
| count_i | input | CNT_W | Word count value to load |
| demand_i | input | 1 | 1 = demand mode, 0 = single mode |
| dreq_i | input | 1 | Transfer request |
| ext_term_n_i | input | 1 | Asynchronous active-low external terminate |
| phase_o | output | 3 | Current phase code (see R3) |
| busy_o | output | 1 | High in any active phase |
| cnt_o | output | CNT_W | Current word count |
| eop_o | output | 1 | One-cycle end-of-process pulse |
| tc_o | output | 1 | One-cycle terminal-count pulse |

## Verification
The hardest case to reach from the ports is a terminate that is latched and then dropped. The pulse has to clear the two-flop synchroniser and be caught in S3 or S4, and the sequencer must then pass through idle before it reaches S2. A second hard case is a terminate caught during S2 itself, which only takes effect at the next word's S2. The stimulus waits for specific phase codes on `phase_o` and times the low pulse on `ext_term_n_i` from there, counting the synchroniser delay. A behavioural model in the bench, with its own count of that delay, predicts every output on every cycle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_S0   = 3'd1,
    PH_S1   = 3'd2,
    PH_S2   = 3'd3,
    PH_S3   = 3'd4,
    PH_S4   = 3'd5
  } phase_e;
endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dcs_term_latch.sv
module dcs_term_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic in_idle,
  input  logic term_req,
  input  logic consume,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (in_idle || consume) pend_q <= 1'b0;
    else if (term_req)         pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

  // R8 / R10: an idle cycle leaves nothing pending
  a_r10_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |=> !pend_o);
  // R9: an active request is caught
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle && !consume && term_req) |=> pend_o);
endmodule

// File: rtl/dcs_word_counter.sv
module dcs_word_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      wrap_q <= 1'b0;
    end else if (dec) begin
      cnt_q  <= cnt_q - ONE;
      wrap_q <= (cnt_q == '0);
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  // R4: one step down per decrement
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt_o == $past(cnt_o) - ONE));
  // R5: rollover from zero is flagged
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt_o == '0) |=> (wrap_o && cnt_o == '1));
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             demand_i,
  input  logic             dreq_i,
  input  logic             ext_term_n_i,
  output logic [2:0]       phase_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eop_o,
  output logic             tc_o
);
  import dcs_pkg::*;

  phase_e phase_q, phase_d;
  logic   armed_q, eop_q, tc_q;
  logic   term_n_s, term_pend, wrap;
  logic   load_ok, end_term, end_tc, in_idle;

  assign in_idle = (phase_q == PH_IDLE);
  assign load_ok = load_i && in_idle;

  dcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (ext_term_n_i), .q (term_n_s)
  );

  dcs_term_latch u_latch (
    .clk (clk), .rst_n (rst_n), .in_idle (in_idle),
    .term_req (!term_n_s), .consume (end_term), .pend_o (term_pend)
  );

  dcs_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk), .rst_n (rst_n), .load (load_ok), .load_val (count_i),
    .dec (phase_q == PH_S3), .cnt_o (cnt_o), .wrap_o (wrap)
  );

  always_comb begin
    phase_d  = phase_q;
    end_term = 1'b0;
    end_tc   = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (!load_ok && armed_q && dreq_i) phase_d = PH_S0;
      PH_S0:   phase_d = PH_S1;
      PH_S1:   phase_d = PH_S2;
      PH_S2:   if (term_pend) begin
                 phase_d  = PH_IDLE;
                 end_term = 1'b1;
               end else begin
                 phase_d  = PH_S3;
               end
      PH_S3:   phase_d = PH_S4;
      PH_S4:   if (wrap) begin
                 phase_d = PH_IDLE;
                 end_tc  = 1'b1;
               end else if (demand_i && dreq_i) begin
                 phase_d = PH_S1;
               end else begin
                 phase_d = PH_IDLE;
               end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      armed_q <= 1'b0;
      eop_q   <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      eop_q   <= end_term || end_tc;
      tc_q    <= end_tc;
      if (load_ok)                 armed_q <= 1'b1;
      else if (end_term || end_tc) armed_q <= 1'b0;
    end
  end

  assign phase_o = phase_q;
  assign busy_o  = !in_idle;
  assign eop_o   = eop_q;
  assign tc_o    = tc_q;

  // R3: fixed active order
  a_r3_s0_s1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd1) |=> (phase_o == 3'd2));
  a_r3_s1_s2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd2) |=> (phase_o == 3'd3));
  a_r3_s3_s4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd4) |=> (phase_o == 3'd5));
  // R9: pending terminate acted on in S2
  a_r9_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 3'd3 && term_pend) |=> (phase_o == 3'd0 && eop_o && !tc_o));
  // R5: terminal count implies end of process, one cycle only
  a_r5_tc_eop: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> eop_o);
  a_r5_eop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eop_o |=> !eop_o);
  // R2: a load while active leaves the count alone
  a_r2_busy_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && phase_o == 3'd1) |=> (cnt_o == $past(cnt_o)));
endmodule

// File: tb/dma_cycle_seq_tb.sv
module dma_cycle_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic load_i = 0, demand_i = 0, dreq_i = 0, ext_term_n_i = 1;
  logic [CW-1:0] count_i = '0;
  logic [2:0] phase_o;
  logic busy_o, eop_o, tc_o;
  logic [CW-1:0] cnt_o;

  int checks = 0, failures = 0, eop_seen = 0;
  bit done = 0;

  // behavioural reference state
  int m_phase = 0, m_cnt = 0, m_armed = 0, m_eop = 0, m_tc = 0;
  int m_wrap = 0, m_pend = 0;
  int term_hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cycle_seq #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .count_i(count_i),
    .demand_i(demand_i), .dreq_i(dreq_i), .ext_term_n_i(ext_term_n_i),
    .phase_o(phase_o), .busy_o(busy_o), .cnt_o(cnt_o), .eop_o(eop_o), .tc_o(tc_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_armed = 0; m_eop = 0; m_tc = 0;
      m_wrap = 0; m_pend = 0; term_hist = {1, 1};
    end else begin
      int term_seen, n_phase, n_end_t, n_end_c, ld;
      term_seen = (term_hist[0] == 0);
      void'(term_hist.pop_front());
      term_hist.push_back(int'(ext_term_n_i));
      ld = (load_i && m_phase == 0);
      n_phase = m_phase; n_end_t = 0; n_end_c = 0;
      case (m_phase)
        0: if (!ld && m_armed && dreq_i) n_phase = 1;
        1: n_phase = 2;
        2: n_phase = 3;
        3: if (m_pend) begin n_phase = 0; n_end_t = 1; end else n_phase = 4;
        4: n_phase = 5;
        default: if (m_wrap) begin n_phase = 0; n_end_c = 1; end
                 else if (demand_i && dreq_i) n_phase = 2;
                 else n_phase = 0;
      endcase
      if (m_phase == 0 || n_end_t) m_pend = 0;
      else if (term_seen) m_pend = 1;
      if (ld) begin m_cnt = int'(count_i); m_wrap = 0; end
      else if (m_phase == 4) begin m_wrap = (m_cnt == 0); m_cnt = (m_cnt - 1) & MASK; end
      if (ld) m_armed = 1; else if (n_end_t || n_end_c) m_armed = 0;
      m_eop = n_end_t || n_end_c;
      m_tc = n_end_c;
      m_phase = n_phase;
    end
  end

  // one cycle: compare every output just after the edge, then return to drive
  task automatic step();
    @(posedge clk); #1;
    if (eop_o) eop_seen++;
    check("R3 phase", int'(phase_o), m_phase);
    check("R3 busy", int'(busy_o), int'(m_phase != 0));
    check("R4 R2 count", int'(cnt_o), m_cnt);
    check("R9 R11 eop", int'(eop_o), m_eop);
    check("R5 tc", int'(tc_o), m_tc);
  endtask

  task automatic wait_phase(input int ph);
    for (int i = 0; i < 50; i++) begin
      if (int'(phase_o) == ph) return;
      step();
    end
  endtask

  task automatic do_load(input int v);
    load_i = 1; count_i = CW'(v); step(); load_i = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R1 phase", int'(phase_o), 0);
    check("R1 cnt", int'(cnt_o), 0);
    check("R1 eop", int'(eop_o), 0);
    check("R1 tc", int'(tc_o), 0);
    check("R1 busy", int'(busy_o), 0);
    rst_n = 1;
    dreq_i = 1; step(); step();
    check("R1 not armed", int'(phase_o), 0);

    // single mode, count 2 -> three words, then terminal count
    dreq_i = 0; do_load(2);
    check("R2 load", int'(cnt_o), 2);
    dreq_i = 1; step();
    wait_phase(2); load_i = 1; count_i = 16'h1234; step(); load_i = 0;
    wait_phase(5); step();
    check("R6 single returns idle", int'(phase_o), 0);
    eop_seen = 0;
    for (int i = 0; i < 30; i++) step();
    check("R5 tc pulses seen", eop_seen, 1);
    check("R5 wrapped", int'(cnt_o), MASK);
    check("R5 disarmed", int'(phase_o), 0);

    // demand mode with a pause; terminate pulse while idle
    demand_i = 1; dreq_i = 0; do_load(5);
    dreq_i = 1; wait_phase(5); step();
    check("R7 demand continues", int'(phase_o), 2);
    wait_phase(5); dreq_i = 0; step();
    check("R7 pause to idle", int'(phase_o), 0);
    eop_seen = 0;
    ext_term_n_i = 0; step(); step(); ext_term_n_i = 1;
    for (int i = 0; i < 4; i++) step();
    dreq_i = 1;
    for (int i = 0; i < 8; i++) step();
    check("R8 idle pulse ignored", eop_seen, 0);
    check("R8 still running", int'(busy_o), 1);
    for (int i = 0; i < 30; i++) step();
    check("R7 ran to terminal count", eop_seen, 1);

    // terminate while active, demand mode
    dreq_i = 0; do_load(20); dreq_i = 1;
    wait_phase(1); ext_term_n_i = 0; step(); ext_term_n_i = 1;
    eop_seen = 0;
    for (int i = 0; i < 14; i++) step();
    check("R9 terminated", eop_seen, 1);
    check("R9 idle after", int'(phase_o), 0);
    check("R11 count left", int'(cnt_o), 19);

    // terminate in S2 of demand burst: applies at next S2
    do_load(20); wait_phase(3); ext_term_n_i = 0; step(); ext_term_n_i = 1;
    eop_seen = 0;
    for (int i = 0; i < 12; i++) step();
    check("R9 next S2", eop_seen, 1);
    check("R11 S2 count", int'(cnt_o), 19);

    // single mode: caught late, dropped at idle
    demand_i = 0; dreq_i = 0; do_load(20); dreq_i = 1;
    wait_phase(3); ext_term_n_i = 0; step(); ext_term_n_i = 1;
    dreq_i = 0; eop_seen = 0;
    for (int i = 0; i < 6; i++) step();
    dreq_i = 1;
    for (int i = 0; i < 7; i++) step();
    check("R10 dropped", eop_seen, 0);
    check("R10 second word counted", int'(cnt_o), 18);
    dreq_i = 0;
    for (int i = 0; i < 6; i++) step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule